// File: doc/BRIEF.md
# Dual-Compare Up Counter

This block is a 16-bit up counter with two compare channels behind a small byte-addressed register window. Software starts the counter with a run bit in a two-byte control register. While it runs the counter adds one on every clock. While it is stopped the counter is held at zero and also reads as zero.

Each compare channel has a 16-bit compare value and a byte-wide channel control register. When a channel is enabled and the running counter equals its compare value, that channel's event output is high for exactly that one cycle. A third event output marks the cycle in which the counter rolls over from all ones to zero.

All registers are written in a single clock cycle on the rising edge. A read is combinational from the address, so read data is valid in the same cycle the address is presented.

Top module: `up_cmp_timer`

## Requirements
- R1: After synchronous reset every register is zero, the counter reads zero and all three event outputs are low.
- R2: The control register occupies offsets 0x84 (high byte) and 0x85 (low byte). Each byte can be written or read on its own. A halfword access at 0x84 moves both bytes, with 0x84 in bits 15:8 and 0x85 in bits 7:0. A halfword access at 0x85 is ignored and reads zero.
- R3: Bit 7 of the byte at 0x84 is the run bit. While it is set the counter adds one per clock, starting from zero on the first edge after the setting write. While it is clear the counter is zero from the edge after the clearing write onward.
- R4: The counter is read at 0xA4. A halfword read gives all 16 bits and a byte read gives bits 7:0 in the low byte. While stopped it reads zero. Writes to 0xA4 have no effect.
- R5: Compare A sits at 0xC4 and compare B at 0xD4. A halfword write or read moves all 16 bits. A byte write replaces only bits 7:0, and a byte read returns bits 7:0.
- R6: The channel control bytes sit at 0xB4 (A) and 0xB5 (B) and are byte-only. A halfword write there is ignored and a halfword read there returns zero.
- R7: The compare A event output is high in each cycle in which the counter runs, bit 0 of the 0xB4 byte is set and the counter equals compare A. It is low otherwise.
- R8: The compare B event output follows the same rule using 0xB5 bit 0 and compare B, independently of channel A.
- R9: The wrap event output is high in the cycle in which the running counter holds 0xFFFF. The counter is zero in the following cycle.
- R10: Unmapped offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the access |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Combinational read data; byte reads return the byte in bits 7:0 |
| wrap_evt | output | 1 | Counter rollover event |
| match_a_evt | output | 1 | Compare channel A event |
| match_b_evt | output | 1 | Compare channel B event |

## Verification
Compare matching is checked over a run of consecutive counter values on both sides of each compare point. This shows that an event is high only on the equal value and not one cycle early or late. The two channels are set to different values, which tells crossed channel wiring apart from correct wiring. Disabling one channel while the other keeps working shows that each enable gates only its own channel. The counter is run through its full range to reach rollover, and a match is checked just after the wrap to confirm the count restarts at zero. Byte and halfword patterns on the same offsets separate partial-write behaviour from full-width writes and from the illegal accesses that must be ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 8;
    localparam int BYTE_W  = 8;
    localparam int NCH     = 2;
    localparam int RUN_BIT = 7;
    localparam int CH_EN_BIT = 0;

    localparam logic [ADDR_W-1:0] OFF_CTL_HI = 8'h84;
    localparam logic [ADDR_W-1:0] OFF_CTL_LO = 8'h85;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFF_CHCTL0 = 8'hB4;
    localparam logic [ADDR_W-1:0] OFF_CMP0   = 8'hC4;
    localparam logic [ADDR_W-1:0] CMP_STRIDE = 8'h10;

    typedef struct packed {
        logic [BYTE_W-1:0]                   ctl_hi;
        logic [BYTE_W-1:0]                   ctl_lo;
        logic [NCH-1:0][BYTE_W-1:0]          ch_ctl;
        logic [NCH-1:0][CNT_W-1:0]           ch_cmp;
    } tmr_cfg_t;

    function automatic logic [ADDR_W-1:0] chctl_offset(input int ch);
        return OFF_CHCTL0 + ADDR_W'(ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_offset(input int ch);
        return OFF_CMP0 + ADDR_W'(ch) * CMP_STRIDE;
    endfunction

    function automatic logic [CNT_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
        return {{(CNT_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              half,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  rdata,
    output tmr_cfg_t          cfg
);

    logic ctl_hi_hit, ctl_lo_hit, ctl_lo_read;

    assign ctl_hi_hit  = (addr == OFF_CTL_HI);
    assign ctl_lo_hit  = (addr == OFF_CTL_LO) && !half;
    assign ctl_lo_read = ctl_lo_hit || (ctl_hi_hit && half);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.ctl_hi <= '0;
            cfg.ctl_lo <= '0;
        end else if (wr) begin
            if (ctl_hi_hit && half) begin
                cfg.ctl_hi <= wdata[CNT_W-1:BYTE_W];
                cfg.ctl_lo <= wdata[BYTE_W-1:0];
            end else if (ctl_hi_hit) begin
                cfg.ctl_hi <= wdata[BYTE_W-1:0];
            end else if (ctl_lo_hit) begin
                cfg.ctl_lo <= wdata[BYTE_W-1:0];
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch_regs
        logic chctl_hit, cmp_hit;
        assign chctl_hit = (addr == chctl_offset(ch)) && !half;
        assign cmp_hit   = (addr == cmp_offset(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg.ch_ctl[ch] <= '0;
                cfg.ch_cmp[ch] <= '0;
            end else if (wr) begin
                if (chctl_hit)
                    cfg.ch_ctl[ch] <= wdata[BYTE_W-1:0];
                if (cmp_hit && half)
                    cfg.ch_cmp[ch] <= wdata;
                else if (cmp_hit)
                    cfg.ch_cmp[ch][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (ctl_hi_hit && half)
            rdata = {cfg.ctl_hi, cfg.ctl_lo};
        else if (ctl_hi_hit)
            rdata = zext_byte(cfg.ctl_hi);
        else if (ctl_lo_read)
            rdata = zext_byte(cfg.ctl_lo);
        else if (addr == OFF_COUNT)
            rdata = half ? count : zext_byte(count[BYTE_W-1:0]);
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr == chctl_offset(ch) && !half)
                rdata = zext_byte(cfg.ch_ctl[ch]);
            if (addr == cmp_offset(ch))
                rdata = half ? cfg.ch_cmp[ch] : zext_byte(cfg.ch_cmp[ch][BYTE_W-1:0]);
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_vis,
    output logic             wrap
);

    always_ff @(posedge clk) begin
        if (rst || !run)
            count <= '0;
        else
            count <= count + 1'b1;
    end

    assign count_vis = run ? count : '0;
    assign wrap      = run && (count == {CNT_W{1'b1}});

endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
(
    input  logic             run,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit
);

    assign hit = run && enable && (count == cmp);

endmodule

// File: rtl/up_cmp_timer.sv
module up_cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_half,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              wrap_evt,
    output logic              match_a_evt,
    output logic              match_b_evt
);

    tmr_cfg_t         cfg;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_vis;
    logic             run;
    logic [NCH-1:0]   hits;

    assign run = cfg.ctl_hi[RUN_BIT];

    tmr_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .half  (bus_half),
        .wdata (bus_wdata),
        .count (cnt_vis),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    tmr_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .count     (cnt_q),
        .count_vis (cnt_vis),
        .wrap      (wrap_evt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_match
        tmr_match u_match (
            .run    (run),
            .enable (cfg.ch_ctl[ch][CH_EN_BIT]),
            .count  (cnt_q),
            .cmp    (cfg.ch_cmp[ch]),
            .hit    (hits[ch])
        );
    end

    assign match_a_evt = hits[0];
    assign match_b_evt = hits[1];

endmodule

// File: rtl/up_cmp_timer_chk.sv
module up_cmp_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              wrap_evt,
    input logic              match_a_evt,
    input logic              match_b_evt
);

    // R3: a running counter steps by one on each edge
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        run |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R3: a stopped counter is zero on the next edge
    a_r3_stop_zero: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R9: rollover lands on zero
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> (cnt == '0));

    // R7: a match without a register write cannot repeat in the next cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (match_a_evt && !bus_wr) |=> !match_a_evt);

    // R8: same for channel B
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (match_b_evt && !bus_wr) |=> !match_b_evt);

    // R1: no events while stopped
    a_r1_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> !(wrap_evt || match_a_evt || match_b_evt));

    // R4: a stopped counter reads back zero
    a_r4_stopped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (!run && bus_addr == OFF_COUNT) |-> (bus_rdata == '0));

endmodule

bind up_cmp_timer up_cmp_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .cnt         (cnt_q),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .wrap_evt    (wrap_evt),
    .match_a_evt (match_a_evt),
    .match_b_evt (match_b_evt)
);

// File: tb/up_cmp_timer_tb.sv
module up_cmp_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_half = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        wrap_evt, match_a_evt, match_b_evt;

    typedef struct {
        int          sel;   // 0 rdata, 1 wrap, 2 match A, 3 match B
        logic [15:0] exp;
        string       req;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state derived from the requirements
    bit          m_run = 1'b0;
    bit          m_run_next = 1'b0;
    logic [15:0] m_cnt = 16'h0000;

    always #2 clk = ~clk;

    up_cmp_timer u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_half    (bus_half),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wrap_evt    (wrap_evt),
        .match_a_evt (match_a_evt),
        .match_b_evt (match_b_evt)
    );

    // monitor: compare queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [15:0] act;
                it = exp_q.pop_front();
                case (it.sel)
                    0: act = bus_rdata;
                    1: act = {15'd0, wrap_evt};
                    2: act = {15'd0, match_a_evt};
                    default: act = {15'd0, match_b_evt};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic finish_cycle();
        @(posedge clk);
        if (m_run) m_cnt = m_cnt + 16'd1;
        else       m_cnt = 16'h0000;
        m_run = m_run_next;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(input int sel, input logic [15:0] exp, input string req);
        exp_item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input bit half, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_half = half; bus_wdata = d;
        if (a == 8'h84) m_run_next = half ? d[15] : d[7];
        finish_cycle();
    endtask

    task automatic rd(input logic [7:0] a, input bit half, input logic [15:0] exp, input string req);
        bus_wr = 1'b0; bus_addr = a; bus_half = half;
        push(0, exp, req);
        finish_cycle();
    endtask

    task automatic evts(input bit ea, input bit eb, input bit ew, input string req);
        bus_wr = 1'b0; bus_addr = 8'h00;
        push(2, {15'd0, ea}, req);
        push(3, {15'd0, eb}, req);
        push(1, {15'd0, ew}, req);
        finish_cycle();
    endtask

    task automatic idle(input int n);
        bus_wr = 1'b0; bus_addr = 8'h00;
        for (int i = 0; i < n; i++) finish_cycle();
    endtask

    function automatic logic [15:0] cnt_read(input bit half);
        logic [15:0] v;
        v = m_run ? m_cnt : 16'h0000;
        return half ? v : {8'h00, v[7:0]};
    endfunction

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'hA4, 1'b1, 16'h0000, "R1 counter");
        rd(8'h84, 1'b1, 16'h0000, "R1 control");
        rd(8'hC4, 1'b1, 16'h0000, "R1 cmpA");
        rd(8'hD4, 1'b1, 16'h0000, "R1 cmpB");
        evts(1'b0, 1'b0, 1'b0, "R1 events");

        // R2 control bytes and packed halfword
        wr(8'h85, 1'b0, 16'h005A);
        wr(8'h84, 1'b0, 16'h0003);
        rd(8'h84, 1'b1, 16'h035A, "R2 packed read");
        rd(8'h85, 1'b0, 16'h005A, "R2 low byte");
        wr(8'h84, 1'b1, 16'h1234);
        rd(8'h84, 1'b1, 16'h1234, "R2 halfword write");
        rd(8'h84, 1'b0, 16'h0012, "R2 high byte");
        wr(8'h85, 1'b1, 16'hFFFF);
        rd(8'h85, 1'b1, 16'h0000, "R2 halfword at low byte reads zero");
        rd(8'h84, 1'b1, 16'h1234, "R2 halfword at low byte ignored");

        // R5 compare registers
        wr(8'hC4, 1'b1, 16'h1234);
        wr(8'hC4, 1'b0, 16'hFF56);
        rd(8'hC4, 1'b1, 16'h1256, "R5 byte write keeps high byte");
        rd(8'hC4, 1'b0, 16'h0056, "R5 byte read");
        wr(8'hC4, 1'b1, 16'h0005);
        wr(8'hD4, 1'b1, 16'h0003);
        rd(8'hD4, 1'b1, 16'h0003, "R5 cmpB");

        // R6 channel control bytes
        wr(8'hB4, 1'b0, 16'h0001);
        wr(8'hB5, 1'b0, 16'h0001);
        wr(8'hB4, 1'b1, 16'hFFFE);
        rd(8'hB4, 1'b0, 16'h0001, "R6 halfword write ignored");
        rd(8'hB4, 1'b1, 16'h0000, "R6 halfword read zero");
        rd(8'hB5, 1'b0, 16'h0001, "R6 channel B byte");

        // R10 unmapped
        wr(8'h10, 1'b1, 16'hBEEF);
        rd(8'h10, 1'b1, 16'h0000, "R10 unmapped read");
        rd(8'h84, 1'b1, 16'h1234, "R10 control untouched");
        rd(8'hC4, 1'b1, 16'h0005, "R10 cmpA untouched");

        // R4 writes to counter ignored while stopped
        wr(8'hA4, 1'b1, 16'h7777);
        rd(8'hA4, 1'b1, 16'h0000, "R4 stopped reads zero");

        // R3 start counting; R7/R8 match windows
        wr(8'h84, 1'b0, 16'h0080);
        for (int k = 0; k < 8; k++)
            evts(m_cnt == 16'd5, m_cnt == 16'd3, 1'b0, "R7 R8 match window");
        rd(8'hA4, 1'b1, cnt_read(1'b1), "R3 count value");
        rd(8'hA4, 1'b0, cnt_read(1'b0), "R4 byte read of counter");
        wr(8'hA4, 1'b1, 16'h0000);
        rd(8'hA4, 1'b1, cnt_read(1'b1), "R4 counter write ignored");

        // R9 wrap
        idle(16'hFFFF - m_cnt);
        evts(1'b0, 1'b0, 1'b1, "R9 wrap pulse");
        rd(8'hA4, 1'b1, 16'h0000, "R9 zero after wrap");
        evts(1'b0, 1'b0, 1'b0, "R9 no pulse after wrap");
        evts(1'b0, 1'b0, 1'b0, "R8 before match");
        evts(1'b0, 1'b1, 1'b0, "R8 match after wrap");

        // R8 independence: disable B, move its compare ahead
        wr(8'hB5, 1'b0, 16'h0000);
        wr(8'hD4, 1'b1, 16'h000A);
        for (int k = 0; k < 6; k++)
            evts(1'b0, 1'b0, 1'b0, "R8 disabled channel quiet");
        wr(8'hB5, 1'b0, 16'h0001);
        wr(8'hD4, 1'b1, m_cnt + 16'd3);
        for (int k = 0; k < 5; k++)
            evts(1'b0, k == 2, 1'b0, "R8 re-enabled match");

        // R7 disabled A with matching compare
        wr(8'hB4, 1'b0, 16'h0000);
        wr(8'hC4, 1'b1, m_cnt + 16'd2);
        for (int k = 0; k < 4; k++)
            evts(1'b0, 1'b0, 1'b0, "R7 disabled channel quiet");

        // R3 stop
        wr(8'h84, 1'b0, 16'h0000);
        rd(8'hA4, 1'b1, 16'h0000, "R3 stopped counter");
        evts(1'b0, 1'b0, 1'b0, "R3 no events stopped");
        rd(8'hA4, 1'b1, 16'h0000, "R3 held at zero");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule